// File: doc/BRIEF.md
# Strobe-Serviced Watchdog Timer

This block watches a processor's liveness. Software must pull a strobe line from high to low more often than a chosen period. If it fails to, the block raises a reset request for a fixed number of cycles. The request is meant to be ORed into the chip's supervisory reset. A two-bit select input chooses one of three periods (short, medium, long). All periods and the request width are parameters counted in clock cycles. The strobe is asynchronous, so it passes through a two-flop synchronizer before its falling edge is detected.

Timing is held off while the system reset input is active, and the counter stays at the start of a full period. Once that input goes inactive, the count runs. A falling strobe edge restarts a full period. Rising edges and steady levels do nothing. When the count expires, the request pulse is issued. When the pulse ends, a new period starts without any strobe. The select value is read only when a period is loaded, so changing it in the middle of a period does not alter the count already running.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, and for as long as `sys_rst_act` stays high afterwards, `wdt_rst_req` is 0.
- R2: With `period_sel` = 2'b00, `wdt_rst_req` rises exactly SHORT_CYC clock edges after the first edge that samples `sys_rst_act` low, if there is no strobe.
- R3: `period_sel` = 2'b01 gives MID_CYC cycles. Both 2'b10 and 2'b11 give LONG_CYC cycles.
- R4: A high-to-low change on `strobe_in` reloads the full period on the third clock edge after the change. The expiry then follows exactly that period after the reload edge.
- R5: Rising edges and steady levels on `strobe_in` do not restart the period.
- R6: Each reset request stays high for exactly PULSE_CYC cycles.
- R7: After a request ends, a new full period starts on the edge that ends the request, with no strobe needed. The next request rises one period after the falling edge of the previous one.
- R8: Falling strobe edges that arrive while a request is high are ignored. The next request comes one full period after the end of the current one.
- R9: Driving `sys_rst_act` high in the middle of a period clears the count. After `sys_rst_act` is released, a complete period elapses before any request.
- R10: A change of `period_sel` in the middle of a period takes effect only at the next reload. The period already running keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_rst_act | input | 1 | High while the system reset is active; holds the period count |
| strobe_in | input | 1 | Service strobe from software; its falling edge restarts the period |
| period_sel | input | 2 | Period choice: 00 short, 01 medium, 10 or 11 long |
| wdt_rst_req | output | 1 | Reset request, high for PULSE_CYC cycles on expiry |

## Verification
Each request edge is due at a cycle that follows from the stimulus:
- The rising edge comes the period length after `sys_rst_act` is released.
- After a strobe fall, the rising edge comes the period plus three cycles later (two synchronizer stages and the edge register).
- The falling edge comes PULSE_CYC after the rising edge.
- The next rising edge after an undisturbed request comes one period after its falling edge.

The driver counts cycles on a free-running counter and queues the exact cycle of every rising and falling edge it expects. The monitor samples the request on falling clock edges and checks every change it sees against the head of that queue. A request that arrives early, late, with the wrong width or with no expectation queued is therefore caught. So is a strobe that wrongly services the timer or a select change that takes effect too early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WDT_LOAD  = 2'd0,
    WDT_RUN   = 2'd1,
    WDT_PULSE = 2'd2
  } wdt_state_e;

  localparam logic [1:0] SEL_SHORT = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic strobe_fall
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= strobe_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign strobe_fall = prev_q & ~sync_q;

endmodule

// File: rtl/wdt_period_mux.sv
module wdt_period_mux #(
  parameter int unsigned SHORT_CYC = 150,
  parameter int unsigned MID_CYC   = 600,
  parameter int unsigned LONG_CYC  = 1200,
  localparam int unsigned CNT_W    = $clog2(LONG_CYC + 1)
) (
  input  logic [1:0]       period_sel,
  output logic [CNT_W-1:0] period_len
);

  import wdt_pkg::*;

  always_comb begin
    unique case (period_sel)
      SEL_SHORT: period_len = CNT_W'(SHORT_CYC);
      SEL_MID:   period_len = CNT_W'(MID_CYC);
      default:   period_len = CNT_W'(LONG_CYC);
    endcase
  end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned LONG_CYC  = 1200,
  parameter int unsigned PULSE_CYC = 250,
  localparam int unsigned CNT_W    = $clog2(LONG_CYC + 1),
  localparam int unsigned PLS_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             service,
  input  logic [CNT_W-1:0] period_len,
  output logic             req
);

  import wdt_pkg::*;

  wdt_state_e       state_q, state_d;
  logic [CNT_W-1:0] elapsed_q, elapsed_d;
  logic [CNT_W-1:0] limit_q, limit_d;
  logic [PLS_W-1:0] pcnt_q, pcnt_d;
  logic             cnt_en, pls_en;

  always_comb begin
    state_d   = state_q;
    elapsed_d = elapsed_q;
    limit_d   = limit_q;
    pcnt_d    = pcnt_q;
    cnt_en    = 1'b0;
    pls_en    = 1'b0;
    unique case (state_q)
      WDT_LOAD: begin
        cnt_en    = 1'b1;
        elapsed_d = '0;
        limit_d   = period_len;
        state_d   = WDT_RUN;
      end
      WDT_RUN: begin
        cnt_en = 1'b1;
        if (hold || service) begin
          elapsed_d = '0;
          limit_d   = period_len;
        end else if (elapsed_q == limit_q - CNT_W'(1)) begin
          pls_en  = 1'b1;
          pcnt_d  = '0;
          state_d = WDT_PULSE;
        end else begin
          elapsed_d = elapsed_q + CNT_W'(1);
        end
      end
      WDT_PULSE: begin
        pls_en = 1'b1;
        if (pcnt_q == PLS_W'(PULSE_CYC - 1)) begin
          cnt_en    = 1'b1;
          elapsed_d = '0;
          limit_d   = period_len;
          state_d   = WDT_RUN;
        end else begin
          pcnt_d = pcnt_q + PLS_W'(1);
        end
      end
      default: state_d = WDT_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WDT_LOAD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      limit_q   <= '0;
    end else if (cnt_en) begin
      elapsed_q <= elapsed_d;
      limit_q   <= limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pls_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  assign req = (state_q == WDT_PULSE);

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned SHORT_CYC = 150,
  parameter int unsigned MID_CYC   = 600,
  parameter int unsigned LONG_CYC  = 1200,
  parameter int unsigned PULSE_CYC = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst_act,
  input  logic       strobe_in,
  input  logic [1:0] period_sel,
  output logic       wdt_rst_req
);

  localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             strobe_fall;
  logic [CNT_W-1:0] period_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign core_rst_n = rst_sync_q[1];

  wdt_strobe_sync u_sync (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .strobe_in   (strobe_in),
    .strobe_fall (strobe_fall)
  );

  wdt_period_mux #(
    .SHORT_CYC (SHORT_CYC),
    .MID_CYC   (MID_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_mux (
    .period_sel (period_sel),
    .period_len (period_len)
  );

  wdt_timer #(
    .LONG_CYC  (LONG_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .hold       (sys_rst_act),
    .service    (strobe_fall),
    .period_len (period_len),
    .req        (wdt_rst_req)
  );

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk #(
  parameter int unsigned SHORT_CYC = 150,
  parameter int unsigned PULSE_CYC = 250
) (
  input logic clk,
  input logic rst_n,
  input logic sys_rst_act,
  input logic wdt_rst_req
);

  int unsigned hi_len;
  int unsigned lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= 0;
      lo_len <= 0;
    end else begin
      hi_len <= wdt_rst_req ? hi_len + 1 : 0;
      lo_len <= wdt_rst_req ? 0 : ((lo_len < 32'hFFFF_FFF0) ? lo_len + 1 : lo_len);
    end
  end

  // R6: request width is exactly PULSE_CYC
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_req) |-> hi_len == PULSE_CYC);

  // R6: a started request is held on the next cycle
  a_r6_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |=> wdt_rst_req);

  // R2, R7: never two requests closer than the shortest period
  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> lo_len >= SHORT_CYC);

  // R9: no expiry on an edge where system reset is active
  a_r9_held_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> !$past(sys_rst_act));

  // R1: output always known
  a_r1_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(wdt_rst_req));

endmodule

bind strobe_watchdog strobe_watchdog_chk #(
  .SHORT_CYC (SHORT_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_rst_act (sys_rst_act),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/test_strobe_watchdog.sv
module test_strobe_watchdog;

  localparam int S_CYC = 40;
  localparam int M_CYC = 80;
  localparam int L_CYC = 120;
  localparam int P_CYC = 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sys_rst_act;
  logic       strobe_in;
  logic [1:0] period_sel;
  logic       wdt_rst_req;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit prev_req = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    bit    level;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strobe_watchdog #(
    .SHORT_CYC (S_CYC),
    .MID_CYC   (M_CYC),
    .LONG_CYC  (L_CYC),
    .PULSE_CYC (P_CYC)
  ) i_strobe_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_act (sys_rst_act),
    .strobe_in   (strobe_in),
    .period_sel  (period_sel),
    .wdt_rst_req (wdt_rst_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // driver side: queue a full request (rise, then fall after the pulse width)
  task automatic expect_req(input int rise_at, input string tag);
    exp_q.push_back('{at: rise_at, level: 1'b1, tag: tag});
    exp_q.push_back('{at: rise_at + P_CYC, level: 1'b0, tag: {tag, "/R6"}});
  endtask

  task automatic until_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every output change is compared with the queue head
  always @(negedge clk) begin
    if (mon_en && (wdt_rst_req !== prev_req)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected edge", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check((e.at == cyc) && (e.level == wdt_rst_req), e.tag, cyc, e.at);
      end
    end
    if (mon_en) prev_req = wdt_rst_req;
  end

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int k2;
    rst_n       = 1'b0;
    sys_rst_act = 1'b1;
    strobe_in   = 1'b1;
    period_sel  = 2'b00;
    repeat (5) @(negedge clk);
    check(wdt_rst_req == 1'b0, "R1 in reset", wdt_rst_req, 0);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    repeat (200) @(negedge clk);
    check(wdt_rst_req == 1'b0, "R1 held by system reset", wdt_rst_req, 0);

    // R2 then R7: short period, free running
    k = cyc;
    sys_rst_act = 1'b0;
    expect_req(k + S_CYC, "R2");
    expect_req(k + 2 * S_CYC + P_CYC, "R7");
    until_cyc(k + 2 * S_CYC + 2 * P_CYC + 5);
    sys_rst_act = 1'b1;
    repeat (20) @(negedge clk);

    // R4, R5: falling edges service, rising edges and levels do not; then R8
    period_sel = 2'b01;
    @(negedge clk);
    k = cyc;
    sys_rst_act = 1'b0;
    expect_req(k + 73 + M_CYC, "R4/R5");
    expect_req(k + 73 + M_CYC + P_CYC + M_CYC, "R8");
    until_cyc(k + 20);  strobe_in = 1'b0;
    until_cyc(k + 45);  strobe_in = 1'b1;
    until_cyc(k + 70);  strobe_in = 1'b0;
    until_cyc(k + 100); strobe_in = 1'b1;
    until_cyc(k + 73 + M_CYC + 7); strobe_in = 1'b0;  // inside the pulse
    until_cyc(k + 73 + M_CYC + P_CYC + M_CYC + P_CYC + 5);
    sys_rst_act = 1'b1;
    strobe_in   = 1'b1;
    repeat (20) @(negedge clk);

    // R3: long period for select 10 and 11
    period_sel = 2'b10;
    @(negedge clk);
    k = cyc;
    sys_rst_act = 1'b0;
    expect_req(k + L_CYC, "R3 sel10");
    until_cyc(k + L_CYC + P_CYC + 5);
    sys_rst_act = 1'b1;
    repeat (10) @(negedge clk);
    period_sel = 2'b11;
    @(negedge clk);
    k = cyc;
    sys_rst_act = 1'b0;
    expect_req(k + L_CYC, "R3 sel11");
    until_cyc(k + L_CYC + P_CYC + 5);
    sys_rst_act = 1'b1;
    repeat (10) @(negedge clk);

    // R10: select change mid-period applies at the next reload
    period_sel = 2'b00;
    @(negedge clk);
    k = cyc;
    sys_rst_act = 1'b0;
    expect_req(k + S_CYC, "R10 current");
    expect_req(k + S_CYC + P_CYC + L_CYC, "R10 next");
    until_cyc(k + 10); period_sel = 2'b10;
    until_cyc(k + S_CYC + 2 * P_CYC + L_CYC + 5);
    sys_rst_act = 1'b1;
    period_sel  = 2'b00;
    repeat (10) @(negedge clk);

    // R9: system reset mid-period clears the count
    k = cyc;
    sys_rst_act = 1'b0;
    until_cyc(k + 30); sys_rst_act = 1'b1;
    until_cyc(k + 130);
    check(wdt_rst_req == 1'b0, "R9 no request while held", wdt_rst_req, 0);
    k2 = cyc;
    sys_rst_act = 1'b0;
    expect_req(k2 + S_CYC, "R9 full period");
    until_cyc(k2 + S_CYC + P_CYC + 5);
    sys_rst_act = 1'b1;
    repeat (20) @(negedge clk);

    check(exp_q.size() == 0, "missing expected edges", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule